// File: doc/BRIEF.md
# Linked Control-Block DMA Channel

This block is one DMA channel that takes its work from a chain of control blocks held in ordinary memory. Software writes one or more blocks, each eight 32-bit words long, and pulses `start` with the address of the first block. The channel reads the block, moves the described number of bytes one 32-bit word at a time through the same memory port, and then loads the block named by the block's next pointer. A next pointer of zero ends the chain and the channel goes idle. A next pointer that names an earlier block (or the block itself) forms a ring that runs until `pause` is raised or the channel is reset.

Each block's info word selects the behaviour for that block: whether the source and destination addresses step by 4 after each word or stay fixed (as for a peripheral FIFO), whether source reads are skipped so that zeros are written, whether destination writes are suppressed, whether reads or writes wait on one of 32 peripheral request lines, how many idle cycles are placed between words, whether completion waits for every write to be acknowledged, and whether the block raises the interrupt flag when it finishes.

The memory port is a single request channel with valid/ready handshake: once `mem_req_valid` is high it stays high, with address, write flag and write data unchanged, until a cycle in which `mem_req_ready` is also high; that cycle transfers the request. At most one read is outstanding; its data returns on a one-cycle `mem_rsp_valid` pulse, which the channel always accepts. Each accepted write is acknowledged later by one `mem_wr_ack` pulse; the channel never issues more writes than `MAX_OUTSTANDING` unacknowledged ones.

Top module: `cbdma_engine`

## Requirements
- R1: On `start` while idle, the channel reads the eight words of the control block with reads at consecutive word addresses beginning at `start_addr` with its low five bits forced to zero; word order is info, source, destination, length, stride, next, pad, pad, and `cb_addr` shows that aligned block address while the block runs.
- R2: For a block of length L bytes the channel performs L/4 word moves, each a read at the source address followed by a write of the read data at the destination address; info bit 8 makes the source address step by 4 after each word and info bit 4 does the same for the destination; with a bit clear that address stays fixed.
- R3: With info bit 11 set, the block issues no source reads and every destination write carries the value zero.
- R4: With info bit 7 set, the block issues no destination writes, so destination memory is left unchanged.
- R5: With info bit 10 set, each source read is not issued while `preq[m]` is low, where m is info bits 20:16; info bit 6 gates each destination write the same way; with m equal to zero no gating occurs.
- R6: `waiting_writes` is high whenever at least one accepted write has not been acknowledged; with info bit 3 set, the block does not complete (the channel stays busy and does not fetch on or go idle) until all writes are acknowledged; with bit 3 clear, completion does not wait.
- R7: When a block with info bit 0 set completes, `irq_flag` is set and stays set until `irq_clr`; the channel continues with the next block without waiting; a block with bit 0 clear leaves the flag unchanged.
- R8: After a block completes, a nonzero next pointer makes the channel fetch the block at that pointer (low five bits cleared); a zero next pointer makes `cb_addr` zero and `busy` low.
- R9: In the default (full) configuration the length word's bits 29:2 give the word count and bits 31:30 and 1:0 are ignored; with `LITE` set, only bits 15:2 are used, limiting a block to 65532 bytes.
- R10: Info bits 25:21 give a count N; after each word move at least N idle cycles pass before the next source read of that block, so successive writes of a block are at least N+1 cycles apart.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address, write flag and data do not change in the next cycle.
- R12: While `pause` is high no new request is launched and no block completes, so a ring of blocks that refers back to itself stops advancing without going idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: begin a chain at `start_addr` (ignored while busy) |
| start_addr | input | 32 | Byte address of the first control block |
| pause | input | 1 | Hold off new requests and block completion |
| preq | input | 32 | Peripheral request lines, selected by info bits 20:16 |
| irq_clr | input | 1 | Clears `irq_flag` |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted this cycle when high with valid |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid (one pulse per read) |
| mem_rsp_rdata | input | 32 | Read data |
| mem_wr_ack | input | 1 | One pulse per accepted write |
| busy | output | 1 | Channel is running a chain |
| cb_addr | output | 32 | Address of the current control block, zero when idle |
| irq_flag | output | 1 | Sticky end-of-block interrupt flag |
| waiting_writes | output | 1 | Some accepted write is not yet acknowledged |

## Verification
The hardest state to reach from the ports is a block that has finished moving its data but is held at completion by unacknowledged writes, because an ordinary memory acknowledges quickly and the window closes in a cycle or two. The bench memory model can withhold every write acknowledgement on demand, so a wait-response block is driven into that state and held there for many cycles while the bench confirms the channel is still busy with the waiting flag raised, then released; the same hold with bit 3 clear shows the channel going idle with the flag still up. A self-referencing ring is used in the same spirit to show that pause freezes the request stream without dropping the channel to idle, under random back-pressure on the request channel and random read latency.

// File: rtl/cbdma_pkg.sv
package cbdma_pkg;

  localparam int MAP_W  = 5;
  localparam int GAP_W  = 5;

  // info word bit positions (decoded by the channel)
  localparam int B_INT   = 0;
  localparam int B_WRESP = 3;
  localparam int B_DINC  = 4;
  localparam int B_DGATE = 6;
  localparam int B_DIGN  = 7;
  localparam int B_SINC  = 8;
  localparam int B_SGATE = 10;
  localparam int B_SIGN  = 11;
  localparam int MAP_LSB = 16;
  localparam int GAP_LSB = 21;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREQ,
    ST_FWAIT,
    ST_RD,
    ST_RWAIT,
    ST_WR,
    ST_DONE
  } cbdma_state_e;

  typedef struct packed {
    logic             int_en;
    logic             wait_resp;
    logic             d_inc;
    logic             d_gate;
    logic             d_ign;
    logic             s_inc;
    logic             s_gate;
    logic             s_ign;
    logic [MAP_W-1:0] pmap;
    logic [GAP_W-1:0] gap;
  } cb_ctrl_t;

  function automatic cb_ctrl_t decode_info(input logic [31:0] w);
    cb_ctrl_t c;
    c.int_en    = w[B_INT];
    c.wait_resp = w[B_WRESP];
    c.d_inc     = w[B_DINC];
    c.d_gate    = w[B_DGATE];
    c.d_ign     = w[B_DIGN];
    c.s_inc     = w[B_SINC];
    c.s_gate    = w[B_SGATE];
    c.s_ign     = w[B_SIGN];
    c.pmap      = w[MAP_LSB +: MAP_W];
    c.gap       = w[GAP_LSB +: GAP_W];
    return c;
  endfunction

endpackage

// File: rtl/cbdma_pace.sv
module cbdma_pace
  import cbdma_pkg::*;
#(
  parameter int NUM_PREQ = 1 << MAP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PREQ-1:0] preq,
  input  logic [MAP_W-1:0]    pmap,
  input  logic                s_gate,
  input  logic                d_gate,
  input  logic                gap_load,
  input  logic [GAP_W-1:0]    gap_val,
  output logic                s_ok,
  output logic                d_ok,
  output logic                gap_busy
);

  logic             line_hi;
  logic             ungated;
  logic [GAP_W-1:0] gap_cnt_q;

  assign ungated = (pmap == '0);
  assign line_hi = preq[pmap];
  assign s_ok    = !s_gate || ungated || line_hi;
  assign d_ok    = !d_gate || ungated || line_hi;

  always_ff @(posedge clk) begin
    if (!rst_n)
      gap_cnt_q <= '0;
    else if (gap_load)
      gap_cnt_q <= gap_val;
    else if (gap_cnt_q != '0)
      gap_cnt_q <= gap_cnt_q - 1'b1;
  end

  assign gap_busy = (gap_cnt_q != '0);

  // R10: a freshly loaded nonzero gap must hold off the next cycle
  a_r10_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    gap_load && (gap_val != '0) |=> gap_busy);

endmodule

// File: rtl/cbdma_wtrack.sv
module cbdma_wtrack #(
  parameter int MAX_OUTSTANDING = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_issue,
  input  logic wr_ack,
  output logic pending,
  output logic full
);

  localparam int CNT_W = $clog2(MAX_OUTSTANDING + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUTSTANDING);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      case ({wr_issue, wr_ack})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
  end

  assign pending = (cnt_q != '0);
  assign full    = (cnt_q == CNT_MAX);

  // R6: an acknowledge never arrives with nothing outstanding
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack && !wr_issue |-> pending);

  // R6: the issuing side never exceeds the outstanding limit
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_issue && !wr_ack |-> !full);

endmodule

// File: rtl/cbdma_engine.sv
module cbdma_engine
  import cbdma_pkg::*;
#(
  parameter bit LITE            = 1'b0,
  parameter int MAX_OUTSTANDING = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_addr,
  input  logic        pause,
  input  logic [31:0] preq,
  input  logic        irq_clr,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_rdata,
  input  logic        mem_wr_ack,
  output logic        busy,
  output logic [31:0] cb_addr,
  output logic        irq_flag,
  output logic        waiting_writes
);

  localparam int NUM_PREQ = 1 << MAP_W;
  localparam int CB_WORDS = 8;
  localparam int IDX_W    = $clog2(CB_WORDS);
  localparam int ALIGN_W  = IDX_W + 2;

  cbdma_state_e     state_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      cb_q, info_q, src_q, dst_q, len_q, next_q, data_q;
  logic [31:0]      len_eff;
  cb_ctrl_t         ctl;
  logic             hold_q, irq_q;
  logic             s_ok, d_ok, gap_busy, wt_pend, wt_full;
  logic             fetch_go, rd_go, wr_go, accept, word_done, blk_done;

  assign ctl = decode_info(info_q);

  generate
    if (LITE) begin : g_len_lite
      assign len_eff = {16'd0, mem_rsp_rdata[15:2], 2'b00};
    end else begin : g_len_full
      assign len_eff = {2'b00, mem_rsp_rdata[29:2], 2'b00};
    end
  endgenerate

  cbdma_pace #(.NUM_PREQ(NUM_PREQ)) u_pace (
    .clk      (clk),
    .rst_n    (rst_n),
    .preq     (preq),
    .pmap     (ctl.pmap),
    .s_gate   (ctl.s_gate),
    .d_gate   (ctl.d_gate),
    .gap_load (word_done),
    .gap_val  (ctl.gap),
    .s_ok     (s_ok),
    .d_ok     (d_ok),
    .gap_busy (gap_busy)
  );

  cbdma_wtrack #(.MAX_OUTSTANDING(MAX_OUTSTANDING)) u_wtrack (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_issue (accept && mem_req_write),
    .wr_ack   (mem_wr_ack),
    .pending  (wt_pend),
    .full     (wt_full)
  );

  // request launch conditions; a launched request is held until taken
  always_comb begin
    fetch_go  = (state_q == ST_FREQ) && !pause;
    rd_go     = (state_q == ST_RD) && (len_q != '0) && !ctl.s_ign &&
                !gap_busy && !pause && s_ok;
    wr_go     = (state_q == ST_WR) && !ctl.d_ign && !pause && d_ok && !wt_full;
    mem_req_valid = hold_q || fetch_go || rd_go || wr_go;
    accept    = mem_req_valid && mem_req_ready;
    mem_req_write = (state_q == ST_WR);
    case (state_q)
      ST_FREQ: mem_req_addr = cb_q + {{(32-ALIGN_W){1'b0}}, idx_q, 2'b00};
      ST_WR:   mem_req_addr = dst_q;
      default: mem_req_addr = src_q;
    endcase
    mem_req_wdata = data_q;
    word_done = (state_q == ST_WR) && (ctl.d_ign || accept);
    blk_done  = (state_q == ST_DONE) && !pause && !(ctl.wait_resp && wt_pend);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= mem_req_valid && !mem_req_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cb_q    <= '0;
      info_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      next_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            cb_q    <= {start_addr[31:ALIGN_W], {ALIGN_W{1'b0}}};
            idx_q   <= '0;
            state_q <= ST_FREQ;
          end
        end
        ST_FREQ: begin
          if (accept) state_q <= ST_FWAIT;
        end
        ST_FWAIT: begin
          if (mem_rsp_valid) begin
            case (idx_q)
              3'd0:    info_q <= mem_rsp_rdata;
              3'd1:    src_q  <= mem_rsp_rdata;
              3'd2:    dst_q  <= mem_rsp_rdata;
              3'd3:    len_q  <= len_eff;
              3'd5:    next_q <= mem_rsp_rdata;
              default: ;
            endcase
            if (idx_q == IDX_W'(CB_WORDS - 1)) begin
              state_q <= ST_RD;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_FREQ;
            end
          end
        end
        ST_RD: begin
          if (len_q == '0) begin
            state_q <= ST_DONE;
          end else if (ctl.s_ign) begin
            if (!gap_busy && !pause) begin
              data_q  <= '0;
              state_q <= ST_WR;
            end
          end else if (accept) begin
            state_q <= ST_RWAIT;
          end
        end
        ST_RWAIT: begin
          if (mem_rsp_valid) begin
            data_q  <= mem_rsp_rdata;
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (word_done) begin
            if (ctl.s_inc) src_q <= src_q + 32'd4;
            if (ctl.d_inc) dst_q <= dst_q + 32'd4;
            len_q   <= len_q - 32'd4;
            state_q <= ST_RD;
          end
        end
        ST_DONE: begin
          if (blk_done) begin
            if (next_q == '0) begin
              cb_q    <= '0;
              state_q <= ST_IDLE;
            end else begin
              cb_q    <= {next_q[31:ALIGN_W], {ALIGN_W{1'b0}}};
              idx_q   <= '0;
              state_q <= ST_FREQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      irq_q <= 1'b0;
    else if (blk_done && ctl.int_en)
      irq_q <= 1'b1;
    else if (irq_clr)
      irq_q <= 1'b0;
  end

  assign busy           = (state_q != ST_IDLE);
  assign cb_addr        = cb_q;
  assign irq_flag       = irq_q;
  assign waiting_writes = wt_pend;

  // R11: a stalled request is held unchanged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_write) && $stable(mem_req_wdata));

  // R8: an idle channel reports a zero block address
  a_r8_idle_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cb_addr == '0));

  // R1: a running block address is always 32-byte aligned
  a_r1_cb_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cb_addr[ALIGN_W-1:0] == '0));

  // R4: no write is offered for a destination-ignore block
  a_r4_no_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> !ctl.d_ign);

  // R3: a source-ignore block only ever writes zero
  a_r3_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write && ctl.s_ign |-> (mem_req_wdata == '0));

  // R5: a newly offered gated read sees its request line high
  a_r5_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !hold_q && (state_q == ST_RD) && ctl.s_gate &&
      (ctl.pmap != '0) |-> preq[ctl.pmap]);

  // R12: pause stops any new request from being offered
  a_r12_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pause && !hold_q |-> !mem_req_valid);

endmodule

// File: tb/cbdma_engine_tb.sv
module cbdma_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        pause = 1'b0;
  logic [31:0] preq = '0;
  logic        irq_clr = 1'b0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        mem_wr_ack;
  logic        busy, irq_flag, waiting_writes;
  logic [31:0] cb_addr;

  always #2 clk = ~clk;

  cbdma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .pause(pause), .preq(preq), .irq_clr(irq_clr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .mem_wr_ack(mem_wr_ack),
    .busy(busy), .cb_addr(cb_addr), .irq_flag(irq_flag),
    .waiting_writes(waiting_writes)
  );

  // ---------------- memory model ----------------
  logic [31:0] mem [0:1023];
  logic        rnd_ready = 1'b0, ack_hold = 1'b0, gap_clr = 1'b0;
  logic        bw_en = 1'b0;
  logic [31:0] bw_addr = '0, bw_data = '0;
  logic        rd_busy;
  logic [1:0]  rd_dly;
  logic [31:0] rd_addr;
  int          rd_cnt, wr_cnt, pend, cyc, last_wr, min_gap, hold_bad;
  logic [31:0] first_rd;
  logic        prev_stall;
  logic [31:0] prev_addr, prev_data;
  logic        prev_write;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bw_en) mem[bw_addr[11:2]] <= bw_data;
    if (gap_clr) min_gap <= 1000;
    if (!rst_n) begin
      rd_busy <= 1'b0; mem_rsp_valid <= 1'b0; mem_wr_ack <= 1'b0;
      pend <= 0; mem_req_ready <= 1'b1; rd_cnt <= 0; wr_cnt <= 0;
      prev_stall <= 1'b0; hold_bad <= 0; last_wr <= 0; first_rd <= '0;
    end else begin
      logic do_ack, do_wr;
      mem_rsp_valid <= 1'b0;
      mem_wr_ack    <= 1'b0;
      mem_req_ready <= rnd_ready ? (($urandom % 4) != 0) : 1'b1;
      if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr ||
          mem_req_write != prev_write || mem_req_wdata != prev_data))
        hold_bad <= hold_bad + 1;
      prev_stall <= mem_req_valid && !mem_req_ready;
      prev_addr  <= mem_req_addr;
      prev_data  <= mem_req_wdata;
      prev_write <= mem_req_write;
      if (rd_busy) begin
        if (rd_dly == 2'd0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= mem[rd_addr[11:2]];
          rd_busy <= 1'b0;
        end else rd_dly <= rd_dly - 1'b1;
      end
      do_wr = mem_req_valid && mem_req_ready && mem_req_write;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem[mem_req_addr[11:2]] <= mem_req_wdata;
          wr_cnt <= wr_cnt + 1;
          if (wr_cnt != 0 && (cyc - last_wr) < min_gap && !gap_clr) min_gap <= cyc - last_wr;
          last_wr <= cyc;
        end else begin
          rd_busy <= 1'b1;
          rd_addr <= mem_req_addr;
          rd_dly  <= rnd_ready ? 2'($urandom % 3) : 2'd0;
          rd_cnt  <= rd_cnt + 1;
          first_rd <= mem_req_addr;
        end
      end
      do_ack = !ack_hold && (pend != 0) && (($urandom % 2) == 0);
      mem_wr_ack <= do_ack;
      pend <= pend + (do_wr ? 1 : 0) - (do_ack ? 1 : 0);
    end
  end

  // ---------------- checking helpers ----------------
  int errors = 0, checks = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bw_en = 1'b1; bw_addr = a; bw_data = d;
    @(negedge clk); bw_en = 1'b0;
  endtask

  task automatic put_cb(input logic [31:0] base, input logic [31:0] info,
                        input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] len, input logic [31:0] nxt);
    poke(base, info); poke(base + 4, s); poke(base + 8, d); poke(base + 12, len);
    poke(base + 16, $urandom); poke(base + 20, nxt);
    poke(base + 24, $urandom); poke(base + 28, $urandom);
  endtask

  task automatic kick(input logic [31:0] a);
    @(negedge clk); start = 1'b1; start_addr = a;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle;
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] info_of(input bit sinc, input bit dinc, input bit sign,
      input bit dign, input bit sgate, input bit dgate, input bit wresp, input bit ien,
      input logic [4:0] pm, input logic [4:0] gp);
    return (32'(ien) << 0) | (32'(wresp) << 3) | (32'(dinc) << 4) | (32'(dgate) << 6) |
           (32'(dign) << 7) | (32'(sinc) << 8) | (32'(sgate) << 10) | (32'(sign) << 11) |
           (32'(pm) << 16) | (32'(gp) << 21);
  endfunction

  task automatic fill(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) poke(base + 4 * i, $urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r0, w0;
    logic [31:0] v;
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset busy", 32'(busy), 0);
    chk("R8 reset cb_addr", cb_addr, 0);
    chk("R7 reset irq", 32'(irq_flag), 0);
    chk("R6 reset waiting", 32'(waiting_writes), 0);
    chk("R11 reset valid", 32'(mem_req_valid), 0);

    // R1 R2 R7 R8: two-block chain, unaligned start address
    fill(32'h400, 6);
    put_cb(32'h100, info_of(1,1,0,0,0,0,0,1,0,0), 32'h400, 32'h800, 32'd16, 32'h14C);
    put_cb(32'h140, info_of(1,1,0,0,0,0,0,0,0,0), 32'h410, 32'h810, 32'd8, 32'h0);
    r0 = rd_cnt; w0 = wr_cnt;
    kick(32'h10B);
    repeat (3) @(negedge clk);
    chk("R1 cb_addr aligned", cb_addr, 32'h100);
    wait_idle;
    chk("R1 R2 read count", 32'(rd_cnt - r0), 32'd22);
    chk("R2 write count", 32'(wr_cnt - w0), 32'd6);
    for (int i = 0; i < 6; i++) chk("R2 copy data", mem[(32'h800 >> 2) + i], mem[(32'h400 >> 2) + i]);
    chk("R7 irq set", 32'(irq_flag), 1);
    chk("R8 idle addr", cb_addr, 0);
    chk("R8 idle busy", 32'(busy), 0);
    @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; @(negedge clk);
    chk("R7 irq clear", 32'(irq_flag), 0);

    // R2: fixed source, then fixed destination; R7 no int_en
    fill(32'h600, 3);
    put_cb(32'h180, info_of(0,1,0,0,0,0,0,0,0,0), 32'h600, 32'h880, 32'd12, 32'h0);
    kick(32'h180); wait_idle;
    for (int i = 0; i < 3; i++) chk("R2 fixed src", mem[(32'h880 >> 2) + i], mem[32'h600 >> 2]);
    chk("R7 no irq", 32'(irq_flag), 0);
    w0 = wr_cnt;
    put_cb(32'h180, info_of(1,0,0,0,0,0,0,0,0,0), 32'h600, 32'h8C0, 32'd12, 32'h0);
    kick(32'h180); wait_idle;
    chk("R2 fixed dst last", mem[32'h8C0 >> 2], mem[(32'h600 >> 2) + 2]);
    chk("R2 fixed dst writes", 32'(wr_cnt - w0), 3);

    // R3: source ignore
    for (int i = 0; i < 4; i++) poke(32'h900 + 4 * i, 32'hDEAD0000 + i);
    r0 = rd_cnt;
    put_cb(32'h1C0, info_of(1,1,1,0,0,0,0,0,0,0), 32'h400, 32'h900, 32'd16, 32'h0);
    kick(32'h1C0); wait_idle;
    chk("R3 only fetch reads", 32'(rd_cnt - r0), 8);
    for (int i = 0; i < 4; i++) chk("R3 zero written", mem[(32'h900 >> 2) + i], 0);

    // R4: destination ignore
    for (int i = 0; i < 4; i++) poke(32'h940 + 4 * i, 32'hBEEF0000 + i);
    w0 = wr_cnt;
    put_cb(32'h1C0, info_of(1,1,0,1,0,0,0,0,0,0), 32'h400, 32'h940, 32'd16, 32'h0);
    kick(32'h1C0); wait_idle;
    chk("R4 no writes", 32'(wr_cnt - w0), 0);
    chk("R4 dst untouched", mem[32'h94C >> 2], 32'hBEEF0003);

    // R5: gated source reads on line 5, then map 0 never gated
    put_cb(32'h200, info_of(1,1,0,0,1,0,0,0,5'd5,0), 32'h400, 32'h980, 32'd8, 32'h0);
    r0 = rd_cnt; preq = '0;
    kick(32'h200);
    repeat (60) @(negedge clk);
    chk("R5 held reads", 32'(rd_cnt - r0), 8);
    chk("R5 held busy", 32'(busy), 1);
    preq[5] = 1'b1;
    wait_idle;
    chk("R5 released data", mem[(32'h980 >> 2) + 1], mem[(32'h400 >> 2) + 1]);
    preq = '0;
    put_cb(32'h200, info_of(1,1,0,0,1,1,0,0,5'd0,0), 32'h404, 32'h9C0, 32'd8, 32'h0);
    kick(32'h200); wait_idle;
    chk("R5 map zero ungated", mem[(32'h9C0 >> 2) + 1], mem[(32'h404 >> 2) + 1]);

    // R6: wait for write acknowledgements
    ack_hold = 1'b1;
    w0 = wr_cnt;
    put_cb(32'h240, info_of(1,1,0,0,0,0,1,0,0,0), 32'h400, 32'hA00, 32'd8, 32'h0);
    kick(32'h240);
    while (wr_cnt - w0 < 2) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R6 held busy", 32'(busy), 1);
    chk("R6 waiting flag", 32'(waiting_writes), 1);
    ack_hold = 1'b0;
    wait_idle;
    chk("R6 released idle", 32'(busy), 0);
    chk("R6 flag cleared", 32'(waiting_writes), 0);
    ack_hold = 1'b1;
    put_cb(32'h240, info_of(1,1,0,0,0,0,0,0,0,0), 32'h400, 32'hA00, 32'd8, 32'h0);
    kick(32'h240); wait_idle;
    chk("R6 no-wait idle", 32'(busy), 0);
    chk("R6 no-wait flag up", 32'(waiting_writes), 1);
    ack_hold = 1'b0;
    repeat (30) @(negedge clk);

    // R9: length bits 31:30 and 1:0 ignored
    w0 = wr_cnt;
    put_cb(32'h280, info_of(1,1,0,0,0,0,0,0,0,0), 32'h400, 32'hA40, 32'hC000_0013, 32'h0);
    kick(32'h280); wait_idle;
    chk("R9 clamped words", 32'(wr_cnt - w0), 4);

    // R10: idle cycles between words
    @(negedge clk); gap_clr = 1'b1; @(negedge clk); gap_clr = 1'b0;
    put_cb(32'h280, info_of(1,1,0,0,0,0,0,0,0,5'd6), 32'h400, 32'hA80, 32'd16, 32'h0);
    kick(32'h280); wait_idle;
    chk("R10 min write gap", 32'(min_gap >= 7), 1);

    // random copies under back-pressure
    rnd_ready = 1'b1;
    for (int k = 0; k < 6; k++) begin
      int n;
      logic [31:0] s, d;
      n = 1 + int'($urandom % 12);
      s = 32'h400 + 4 * ($urandom % 32);
      d = 32'hC00 + 4 * ($urandom % 32);
      fill(s, n);
      put_cb(32'h2C0, info_of(1,1,0,0,0,0,k[0],0,0,5'(k)), s, d, 32'(4 * n), 32'h0);
      kick(32'h2C0); wait_idle;
      v = 0;
      for (int i = 0; i < n; i++) if (mem[(d >> 2) + i] !== mem[(s >> 2) + i]) v = v + 1;
      chk("R2 random copy mismatches", v, 0);
    end

    // R12: self-referencing ring, then pause
    put_cb(32'h300, info_of(1,1,0,0,0,0,0,0,0,0), 32'h400, 32'hB00, 32'd8, 32'h300);
    r0 = rd_cnt;
    kick(32'h300);
    repeat (400) @(negedge clk);
    chk("R12 ring runs", 32'((rd_cnt - r0) > 30), 1);
    pause = 1'b1;
    repeat (20) @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt;
    repeat (60) @(negedge clk);
    chk("R12 paused reads", 32'(rd_cnt - r0), 0);
    chk("R12 paused writes", 32'(wr_cnt - w0), 0);
    chk("R12 paused busy", 32'(busy), 1);
    chk("R12 paused block", cb_addr, 32'h300);
    chk("R11 requests held", 32'(hold_bad), 0);
    @(negedge clk); rst_n = 1'b0; pause = 1'b0; rnd_ready = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset stops ring", 32'(busy), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule